// File: doc/BRIEF.md
# 1-Wire Master Slot Generator

This block is the bit-level engine of a 1-Wire bus master. From a system clock it derives a one-microsecond tick. With that tick it times every low pulse, sample point and recovery gap on a single open-drain data line. The block never drives the line high. It only enables a low driver, and the external pull-up restores the high level.

A higher layer issues one command at a time through a small interface. The three commands are a bus reset with presence detection, a one-bit write, and a one-bit read. The block returns a single result bit together with a one-cycle done strobe. For a reset, the result bit is the presence flag. For a read, it is the sampled bit. Byte assembly and device search are not part of this block and belong to the caller.

All line sampling goes through a two-flop synchroniser. All phase timers restart on the clock edge that starts the phase. This makes every pulse width an exact multiple of the microsecond tick.

Top module: `owm_slot_top`

## Requirements
- R1: After reset, `busy` and `done` are low and `busDriveLow` is low (line released).
- R2: Command code `cmdOp`=2'b00 (bus reset) holds `busDriveLow` high for exactly RST_LOW_US µs (480) from the accepting edge.
- R3: During a bus reset, the line is sampled through the synchroniser PRES_SAMPLE_US µs (70) after release. A low level there makes `resultBit` 1 at done, and a high level makes it 0. The reset command completes RST_WAIT_US µs (480) after release, plus recovery.
- R4: Command code 2'b01 with `cmdWrBit`=0 (write 0) holds the line low for W0_LOW_US µs (60).
- R5: Command code 2'b01 with `cmdWrBit`=1 (write 1) holds the line low for SHORT_LOW_US µs (6).
- R6: Command code 2'b10 (read) holds the line low for SHORT_LOW_US µs, samples the synchronised line RD_SAMPLE_US µs (12) after the slot start, and returns that level in `resultBit`.
- R7: A write or read slot lasts SLOT_US µs (65). It is followed by REC_US µs (2) of recovery with the line released. `done` pulses for one cycle on the edge that ends recovery.
- R8: `busy` is high from the accepting edge until the edge that raises `done`. A command presented while `busy` is high is ignored and does not change the pulse widths or the completion time.
- R9: Command code 2'b11 is never accepted: `busy` stays low and the line stays released.
- R10: The line is only pulled low within a command. Every accepted command begins with the line pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command request, taken when idle |
| cmdOp | input | 2 | 00 bus reset, 01 write bit, 10 read bit, 11 unused |
| cmdWrBit | input | 1 | Bit value for a write command |
| busy | output | 1 | Command in progress, including recovery |
| done | output | 1 | One-cycle completion strobe |
| resultBit | output | 1 | Presence flag (reset) or sampled bit (read) |
| busDriveLow | output | 1 | Enable for the open-drain low driver |
| busIn | input | 1 | Raw level of the bus line |

## Verification
Counting from the accepting edge, the line stays low for exactly the nominal low time times CLK_PER_US cycles. `done` rises at the edge (low-phase total + REC_US) × CLK_PER_US after acceptance. That total is 65 µs for slots and 480 + 480 µs for a reset. The bench samples at falling edges and indexes them from the accepting rising edge. It therefore expects `done` at falling edge index (total µs × CLK_PER_US) + 1. It measures the low width as the run of consecutive falling edges with the driver enabled. A slave model in the bench drives its low windows by that same index, and every window straddles the sample point by many microseconds. As a result, the two synchroniser cycles never decide a result.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_SLOT,
    ST_RECOVER
  } owmState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic clrTimer;
    logic capture;
    logic invertCapture;
  } owmStrobe_t;

  localparam logic [1:0] OP_RESET = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_NONE  = 2'b11;

endpackage

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int CLK_PER_US = 2,
  parameter int US_W       = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  owmStrobe_t      strobe,
  input  logic            busIn,
  output logic            usTick,
  output logic [US_W-1:0] usCount,
  output logic            sampleBit
);

  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] preCnt;
  logic syncA, syncB;

  assign usTick = (preCnt == PRE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      usCount <= '0;
    end else if (strobe.clrTimer) begin
      preCnt  <= '0;
      usCount <= '0;
    end else if (usTick) begin
      preCnt  <= '0;
      usCount <= usCount + 1'b1;
    end else begin
      preCnt  <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      syncB <= 1'b1;
    end else begin
      syncA <= busIn;
      syncB <= syncA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleBit <= 1'b0;
    else if (strobe.capture) sampleBit <= syncB ^ strobe.invertCapture;
  end

  // R2
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_LAST);

  // R3
  sample_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.capture) |-> $stable(sampleBit));

endmodule

// File: rtl/owm_control.sv
module owm_control
  import owm_pkg::*;
#(
  parameter int US_W           = 10,
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_WAIT_US    = 480,
  parameter int SLOT_US        = 65,
  parameter int W0_LOW_US      = 60,
  parameter int SHORT_LOW_US   = 6,
  parameter int RD_SAMPLE_US   = 12,
  parameter int REC_US         = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic            cmdWrBit,
  input  logic            usTick,
  input  logic [US_W-1:0] usCount,
  output owmStrobe_t      strobe,
  output logic            busy,
  output logic            done,
  output logic            driveLow
);

  owmState_t state, stateNext;
  logic [US_W-1:0] lowUs;
  logic isRead, accept;

  function automatic logic reached(input logic tick, input logic [US_W-1:0] cnt, input int lim);
    return tick && (cnt == US_W'(lim - 1));
  endfunction

  assign accept = (state == ST_IDLE) && cmdValid && (cmdOp != OP_NONE);

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        stateNext       = (cmdOp == OP_RESET) ? ST_RST_LOW : ST_SLOT;
        strobe.clrTimer = 1'b1;
      end
      ST_RST_LOW: if (reached(usTick, usCount, RST_LOW_US)) begin
        stateNext       = ST_RST_WAIT;
        strobe.clrTimer = 1'b1;
      end
      ST_RST_WAIT: begin
        if (reached(usTick, usCount, PRES_SAMPLE_US)) begin
          strobe.capture       = 1'b1;
          strobe.invertCapture = 1'b1;
        end
        if (reached(usTick, usCount, RST_WAIT_US)) begin
          stateNext       = ST_RECOVER;
          strobe.clrTimer = 1'b1;
        end
      end
      ST_SLOT: begin
        if (isRead && reached(usTick, usCount, RD_SAMPLE_US)) strobe.capture = 1'b1;
        if (reached(usTick, usCount, SLOT_US)) begin
          stateNext       = ST_RECOVER;
          strobe.clrTimer = 1'b1;
        end
      end
      ST_RECOVER: if (reached(usTick, usCount, REC_US)) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      lowUs  <= '0;
      isRead <= 1'b0;
      done   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_RECOVER) && (stateNext == ST_IDLE);
      if (accept) begin
        isRead <= (cmdOp == OP_READ);
        lowUs  <= (cmdOp == OP_WRITE && !cmdWrBit) ? US_W'(W0_LOW_US) : US_W'(SHORT_LOW_US);
      end
    end
  end

  assign busy     = (state != ST_IDLE);
  assign driveLow = (state == ST_RST_LOW) || ((state == ST_SLOT) && (usCount < lowUs));

  // R10
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !driveLow);

  // R10
  start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> driveLow);

  // R7
  recover_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECOVER) |-> !driveLow);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R9
  unused_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && cmdOp == OP_NONE) |=> !busy);

endmodule

// File: rtl/owm_slot_top.sv
module owm_slot_top
  import owm_pkg::*;
#(
  parameter int CLK_PER_US     = 2,
  parameter int RST_LOW_US     = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RST_WAIT_US    = 480,
  parameter int SLOT_US        = 65,
  parameter int W0_LOW_US      = 60,
  parameter int SHORT_LOW_US   = 6,
  parameter int RD_SAMPLE_US   = 12,
  parameter int REC_US         = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic       cmdWrBit,
  output logic       busy,
  output logic       done,
  output logic       resultBit,
  output logic       busDriveLow,
  input  logic       busIn
);

  localparam int MAX_US = (RST_LOW_US > RST_WAIT_US) ? RST_LOW_US : RST_WAIT_US;
  localparam int US_W   = $clog2(MAX_US + 2);

  owmStrobe_t strobe;
  logic usTick;
  logic [US_W-1:0] usCount;

  owm_datapath #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busIn(busIn),
    .usTick(usTick), .usCount(usCount), .sampleBit(resultBit)
  );

  owm_control #(
    .US_W(US_W), .RST_LOW_US(RST_LOW_US), .PRES_SAMPLE_US(PRES_SAMPLE_US),
    .RST_WAIT_US(RST_WAIT_US), .SLOT_US(SLOT_US), .W0_LOW_US(W0_LOW_US),
    .SHORT_LOW_US(SHORT_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US), .REC_US(REC_US)
  ) uControl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdWrBit(cmdWrBit),
    .usTick(usTick), .usCount(usCount), .strobe(strobe),
    .busy(busy), .done(done), .driveLow(busDriveLow)
  );

endmodule

// File: tb/sim_owm_slot_top.sv
module sim_owm_slot_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int REC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic cmdWrBit = 1'b0;
  logic busy, done, resultBit, busDriveLow, busIn;
  logic slaveLow = 1'b0;

  int checks = 0;
  int errors = 0;

  assign busIn = !(busDriveLow || slaveLow);

  always #(CLK_PERIOD/2) clk = ~clk;

  owm_slot_top #(.CLK_PER_US(CPU), .REC_US(REC)) u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdWrBit(cmdWrBit),
    .busy(busy), .done(done), .resultBit(resultBit),
    .busDriveLow(busDriveLow), .busIn(busIn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic runCase(input int op, input int wb, input int resp);
    int idx = 0, lowCnt = 0, doneIdx = -1;
    bit lowEnded = 0, busyBad = 0, relow = 0, res = 0;
    int expLow, expDone;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdWrBit = wb[0];
    @(posedge clk);
    while (doneIdx < 0 && idx < 5000) begin
      @(negedge clk);
      idx++;
      cmdValid = 1'b0;
      if (idx == 10) begin
        cmdValid = 1'b1; cmdOp = 2'b01; cmdWrBit = ~wb[0];
      end
      if (op == 0) slaveLow = (resp != 0) && idx >= 500*CPU && idx <= 630*CPU;
      else if (op == 2) slaveLow = (resp != 0) && idx <= 40*CPU;
      else slaveLow = 1'b0;
      if (done) begin doneIdx = idx; res = resultBit; end
      if ((!done && !busy) || (done && busy)) busyBad = 1;
      if (busDriveLow && !lowEnded) lowCnt++;
      else if (!busDriveLow) lowEnded = 1;
      if (lowEnded && busDriveLow) relow = 1;
    end
    slaveLow = 1'b0;
    cmdValid = 1'b0;
    if (op == 0) begin
      expLow = 480*CPU; expDone = (480 + 480 + REC)*CPU + 1;
    end else begin
      expLow = (op == 1 && wb == 0) ? 60*CPU : 6*CPU;
      expDone = (65 + REC)*CPU + 1;
    end
    if (op == 0) check(lowCnt == expLow, "R2 reset low width", lowCnt, expLow);
    else if (op == 2) check(lowCnt == expLow, "R6 read low width", lowCnt, expLow);
    else if (wb == 0) check(lowCnt == expLow, "R4 write0 low width", lowCnt, expLow);
    else check(lowCnt == expLow, "R5 write1 low width", lowCnt, expLow);
    check(doneIdx == expDone, "R7 completion cycle", doneIdx, expDone);
    check(!busyBad, "R8 busy span / stray command ignored", busyBad, 0);
    check(!relow, "R7 line released after low phase", relow, 0);
    if (op == 0) check(res == (resp != 0), "R3 presence flag", res, resp != 0);
    if (op == 2) check(res == (resp == 0), "R6 read bit", res, resp == 0);
  endtask

  task automatic runUnused(input int wb);
    bit bad = 0;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b11; cmdWrBit = wb[0];
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (busy || busDriveLow || done) bad = 1;
    end
    cmdValid = 1'b0;
    check(!bad, "R9 unused op ignored", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy, "R1 busy after reset", busy, 0);
    check(!done, "R1 done after reset", done, 0);
    check(!busDriveLow, "R1 line released after reset", busDriveLow, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !busDriveLow, "R1 idle after reset release", busy, 0);
    for (int op = 0; op < 4; op++)
      for (int wb = 0; wb < 2; wb++)
        for (int resp = 0; resp < 2; resp++) begin
          if (op == 3) runUnused(wb);
          else runCase(op, wb, resp);
          check(!busDriveLow, "R10 released between commands", busDriveLow, 0);
        end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule